// File: doc/BRIEF.md
# Integrating Switch Debouncer with Hysteresis

This block cleans up a mechanical single-pole contact that pulls its line low when closed and reads high through a pull-up when open. It models, in logic, an RC network that feeds a Schmitt-trigger input. A saturating accumulator plays the part of the capacitor voltage. The accumulator gains a fixed step on each enabled tick while the contact reads open. It loses a separate, independently chosen step on each enabled tick while the contact reads closed. A contact that bounces therefore slows the net movement of the accumulator without starting any timer over.

The clean level goes high only once the accumulator rises past an upper threshold. It goes low only once the accumulator drops past a lower threshold. Anywhere between the two thresholds the level holds. On every change of the clean level, a one-cycle pulse appears on the rising or falling edge output. A free-running tick enable sets the sample rate. With the default constants and a 1 ms tick, one clean transition takes about 20 ms, which covers a 10 ms bounce at roughly half duty. The step sizes, the thresholds and the full-scale value are all parameters. Constants chosen too slow would make the block miss short genuine presses.

Top module: `contact_integrator_debounce`

## Requirements
- R1: The raw input `sw_n` passes through `SYNC_STAGES` flip-flops, which are reset to 1 (open), before it reaches the accumulator. An input change at a clock edge therefore first affects the accumulator `SYNC_STAGES + 1` edges later.
- R2: On a clock edge with `tick_en` high and the synchronized contact open (`sw_n` = 1), the accumulator increases by `UP_STEP` and saturates at `ACC_MAX` without wrapping.
- R3: On a clock edge with `tick_en` high and the synchronized contact closed (`sw_n` = 0), the accumulator decreases by `DOWN_STEP` and saturates at 0 without wrapping.
- R4: On a clock edge with `tick_en` low, the accumulator holds its value, whatever `sw_n` does.
- R5: At each edge, `level_o` becomes 1 if the accumulator is strictly above `HI_TH`, becomes 0 if it is strictly below `LO_TH`, and otherwise keeps its value.
- R6: `rise_o` is high for exactly the one cycle in which `level_o` has just changed from 0 to 1. `fall_o` is high for exactly the one cycle in which it has just changed from 1 to 0. The two are never high together.
- R7: While `rst` is high at a clock edge, the accumulator loads `ACC_MAX`, `level_o` becomes 1, and `rise_o` and `fall_o` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Accumulation enable, one sample per high cycle |
| sw_n | input | 1 | Raw contact, 0 = closed, 1 = open |
| level_o | output | 1 | Debounced contact level, 1 = open |
| rise_o | output | 1 | One-cycle pulse on a 0-to-1 change of level_o |
| fall_o | output | 1 | One-cycle pulse on a 1-to-0 change of level_o |

## Verification
The bench builds the block with `ACC_MAX` = 40, `UP_STEP` = 4, `DOWN_STEP` = 5, `HI_TH` = 30, `LO_TH` = 10 and two synchronizer stages. With these values a full swing takes only a handful of ticks. Both saturation limits, both threshold crossings and the exact latency from the pin to the edge pulse (10 edges falling, 11 rising) are then reached within tens of cycles. Because the two steps are unequal, alternating bounce patterns make the accumulator drift slowly through the band between the thresholds. This exercises the hysteresis hold, while gated and sparse tick patterns exercise the hold on idle cycles.

// File: rtl/debounce_pkg.sv
package debounce_pkg;

    typedef enum logic {
        CONTACT_CLOSED = 1'b0,
        CONTACT_OPEN   = 1'b1
    } contact_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } clean_out_t;

    function automatic int unsigned sat_up(input int unsigned val,
                                           input int unsigned step,
                                           input int unsigned limit);
        int unsigned room;
        room = limit - val;
        if (step >= room) return limit;
        return val + step;
    endfunction

    function automatic int unsigned sat_down(input int unsigned val,
                                             input int unsigned step);
        if (step >= val) return 0;
        return val - step;
    endfunction

endpackage

// File: rtl/db_input_sync.sv
module db_input_sync
    import debounce_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     raw,
    output contact_e contact
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= {sr[STAGES-2:0], raw};
            end
        end
    endgenerate

    assign contact = contact_e'(sr[STAGES-1]);

    // R1: first stage captures the pin each edge
    a_r1_first_stage: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sr[0] == $past(raw));

endmodule

// File: rtl/db_integrator.sv
module db_integrator
    import debounce_pkg::*;
#(
    parameter int unsigned ACC_MAX   = 200,
    parameter int unsigned UP_STEP   = 10,
    parameter int unsigned DOWN_STEP = 20,
    localparam int unsigned ACC_W    = $clog2(ACC_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  contact_e         contact,
    output logic [ACC_W-1:0] acc
);
    logic [ACC_W-1:0] acc_nxt;

    always_comb begin
        if (contact == CONTACT_OPEN)
            acc_nxt = ACC_W'(sat_up(32'(acc), UP_STEP, ACC_MAX));
        else
            acc_nxt = ACC_W'(sat_down(32'(acc), DOWN_STEP));
    end

    always_ff @(posedge clk) begin
        if (rst)          acc <= ACC_W'(ACC_MAX);
        else if (tick_en) acc <= acc_nxt;
    end

    a_r2_never_above_full: assert property (@(posedge clk) disable iff (rst)
        32'(acc) <= ACC_MAX);

    a_r2_open_not_falling: assert property (@(posedge clk) disable iff (rst)
        (tick_en && contact == CONTACT_OPEN) |=> acc >= $past(acc));

    a_r3_closed_falls: assert property (@(posedge clk) disable iff (rst)
        (tick_en && contact == CONTACT_CLOSED && acc != '0) |=> acc < $past(acc));

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(acc));

endmodule

// File: rtl/db_hysteresis.sv
module db_hysteresis
    import debounce_pkg::*;
#(
    parameter int unsigned ACC_W = 8,
    parameter int unsigned HI_TH = 150,
    parameter int unsigned LO_TH = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] acc,
    output clean_out_t       q
);
    logic lvl_nxt;

    always_comb begin
        lvl_nxt = q.level;
        if (32'(acc) > HI_TH)      lvl_nxt = 1'b1;
        else if (32'(acc) < LO_TH) lvl_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{level: 1'b1, rise: 1'b0, fall: 1'b0};
        end else begin
            q.level <= lvl_nxt;
            q.rise  <= lvl_nxt & ~q.level;
            q.fall  <= ~lvl_nxt & q.level;
        end
    end

    a_r5_band_hold: assert property (@(posedge clk) disable iff (rst)
        (32'(acc) >= LO_TH && 32'(acc) <= HI_TH) |=> $stable(q.level));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({q.rise, q.fall}));

    a_r6_rise_tracks: assert property (@(posedge clk) disable iff (rst)
        q.rise |-> (q.level && !$past(q.level)));

    a_r6_fall_tracks: assert property (@(posedge clk) disable iff (rst)
        q.fall |-> (!q.level && $past(q.level)));

endmodule

// File: rtl/contact_integrator_debounce.sv
module contact_integrator_debounce
    import debounce_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ACC_MAX     = 200,
    parameter int unsigned UP_STEP     = 10,
    parameter int unsigned DOWN_STEP   = 20,
    parameter int unsigned HI_TH       = 150,
    parameter int unsigned LO_TH       = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic sw_n,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned ACC_W = $clog2(ACC_MAX + 1);

    contact_e         contact;
    logic [ACC_W-1:0] acc;
    clean_out_t       clean;

    db_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .raw     (sw_n),
        .contact (contact)
    );

    db_integrator #(
        .ACC_MAX   (ACC_MAX),
        .UP_STEP   (UP_STEP),
        .DOWN_STEP (DOWN_STEP)
    ) u_integ (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .contact (contact),
        .acc     (acc)
    );

    db_hysteresis #(
        .ACC_W (ACC_W),
        .HI_TH (HI_TH),
        .LO_TH (LO_TH)
    ) u_hyst (
        .clk (clk),
        .rst (rst),
        .acc (acc),
        .q   (clean)
    );

    assign level_o = clean.level;
    assign rise_o  = clean.rise;
    assign fall_o  = clean.fall;

    // R7: the cycle after a reset edge shows the idle-open state
    a_r7_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (level_o && !rise_o && !fall_o));

endmodule

// File: tb/contact_integrator_debounce_tb_top.sv
module contact_integrator_debounce_tb_top;

    localparam int STAGES = 2;
    localparam int AMAX   = 40;
    localparam int UPS    = 4;
    localparam int DNS    = 5;
    localparam int HI     = 30;
    localparam int LO     = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic sw_n = 1'b1;
    logic level_o, rise_o, fall_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    contact_integrator_debounce #(
        .SYNC_STAGES (STAGES),
        .ACC_MAX     (AMAX),
        .UP_STEP     (UPS),
        .DOWN_STEP   (DNS),
        .HI_TH       (HI),
        .LO_TH       (LO)
    ) dut_i (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .sw_n    (sw_n),
        .level_o (level_o),
        .rise_o  (rise_o),
        .fall_o  (fall_o)
    );

    // behavioural reference
    bit pipe[$];
    int m_acc = AMAX;
    bit m_lvl = 1'b1, m_rise = 1'b0, m_fall = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            pipe = {};
            for (int i = 0; i < STAGES; i++) pipe.push_back(1'b1);
            m_acc = AMAX; m_lvl = 1'b1; m_rise = 1'b0; m_fall = 1'b0;
        end else begin
            bit nl;
            nl = m_lvl;
            if (m_acc > HI) nl = 1'b1;
            else if (m_acc < LO) nl = 1'b0;
            m_rise = nl && !m_lvl;
            m_fall = !nl && m_lvl;
            m_lvl = nl;
            if (tick_en) begin
                if (pipe[0]) m_acc = (m_acc + UPS > AMAX) ? AMAX : m_acc + UPS;
                else         m_acc = (m_acc < DNS) ? 0 : m_acc - DNS;
            end
            void'(pipe.pop_front());
            pipe.push_back(sw_n);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(level_o == m_lvl, "R5 level", level_o, m_lvl);
            check(rise_o == m_rise, "R6 rise", rise_o, m_rise);
            check(fall_o == m_fall, "R6 fall", fall_o, m_fall);
        end
    end

    int n_rise = 0, n_fall = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rise_o) n_rise++;
            if (fall_o) n_fall++;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        cycles(100000);
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        int lat;
        int r0, f0;
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        // R7: idle-open state after reset
        check(level_o == 1'b1 && !rise_o && !fall_o, "R7 reset state",
              {level_o, rise_o, fall_o}, 3'b100);

        // R1 / R3: latency from press at full scale to fall pulse
        tick_en = 1'b1;
        sw_n = 1'b0;
        lat = 0;
        while (!fall_o && lat < 50) begin
            @(negedge clk); lat++;
        end
        check(lat == 10, "R1 R3 press-to-fall edges", lat, 10);
        cycles(20);
        check(level_o == 1'b0, "R3 held closed level", level_o, 0);

        // R2: release from empty, latency to rise pulse
        sw_n = 1'b1;
        lat = 0;
        while (!rise_o && lat < 50) begin
            @(negedge clk); lat++;
        end
        check(lat == 11, "R1 R2 release-to-rise edges", lat, 11);
        cycles(20);
        check(level_o == 1'b1, "R2 saturated open level", level_o, 1);

        // R4: ticks gated off, pin toggles, nothing moves
        tick_en = 1'b0;
        r0 = n_rise; f0 = n_fall;
        for (int i = 0; i < 40; i++) begin
            sw_n = i[0];
            @(negedge clk);
        end
        sw_n = 1'b0;
        cycles(30);
        check(level_o == 1'b1 && n_fall == f0 && n_rise == r0,
              "R4 gated hold", level_o, 1);

        // R4 / R3: sparse ticks while closed
        for (int i = 0; i < 60; i++) begin
            tick_en = (i % 3 == 0);
            @(negedge clk);
        end
        check(level_o == 1'b0, "R4 sparse tick press", level_o, 0);

        // R5: bounce pattern on release, drifting through the band
        tick_en = 1'b1;
        for (int i = 0; i < 80; i++) begin
            sw_n = (i % 3 != 0);
            @(negedge clk);
        end
        sw_n = 1'b1;
        cycles(30);
        check(level_o == 1'b1, "R5 bounced release settles high", level_o, 1);

        // R5: alternating pattern hovers in the band, single fall at most
        f0 = n_fall;
        for (int i = 0; i < 120; i++) begin
            sw_n = i[0];
            @(negedge clk);
        end
        check(n_fall - f0 <= 1, "R6 at most one fall in hover", n_fall - f0, 1);

        // R6: a whole bounce-then-settle press gives exactly one fall
        sw_n = 1'b1;
        cycles(30);
        f0 = n_fall;
        for (int i = 0; i < 30; i++) begin
            sw_n = (i % 4 == 1);
            @(negedge clk);
        end
        sw_n = 1'b0;
        cycles(30);
        check(n_fall - f0 == 1, "R6 one fall per press", n_fall - f0, 1);

        // R7: reset mid-operation returns to idle-open
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        @(negedge clk);
        check(level_o == 1'b1 && !fall_o && !rise_o, "R7 re-reset state",
              {level_o, rise_o, fall_o}, 3'b100);
        cycles(5);
        finish_run();
    end

endmodule